// File: doc/BRIEF.md
# Transceiver Power-Mode Controller

This block sequences a single-wire bus transceiver that carries its own supply regulator. It steps through five modes: power-on reset, ready, operation, transmitter-off and power-down. Supply and regulator conditions arrive as digital flags from analog comparators. The host drives two pins: chip-select/local-wake and transmit data. A fault flag and a bus wake request complete the inputs. From these inputs the block computes the enables for the regulator, receiver, transmitter, bus pull-up and wake detector, and a reset output of the open-drain kind.

Every input passes through a two-flop synchronizer before it reaches the mode logic. A change on an input therefore reaches the mode register at the third rising clock edge after it is applied.

To send the device to sleep, the host holds both pins low while it is in transmitter-off. That low level must last for a configurable number of clock ticks, and the count starts again if either pin rises before it completes.

Top module: `xcvr_pm_ctrl`

## Requirements
- R1: While rst_n is low at a clock edge, the block enters power-on reset. In that mode every enable output is 0 and rst_pull_low is 1.
- R2: When the synchronized low-supply flag is high, the mode becomes power-on reset at the next edge, whatever the current mode. This takes priority over every other transition. Power-on reset moves to ready when the synchronized supply-good flag is high.
- R3: Ready or transmitter-off moves to operation when chip-select is high, transmit is high, the regulator is good and no fault is present. While a fault is present, transmitter-off stays where it is.
- R4: Ready moves to transmitter-off when chip-select is high, transmit is low and the regulator is good.
- R5: Operation moves to transmitter-off on any of these conditions: a falling edge of the synchronized chip-select, a fault, or a regulator that is not good.
- R6: Transmitter-off moves to power-down once the synchronized chip-select and transmit have both been low for DEGLITCH_TICKS consecutive cycles. If either one goes high, the count starts again. When the pins go low just before edge 1, power-down is visible after edge DEGLITCH_TICKS+2 and not before.
- R7: Power-down moves to ready on a bus wake request or on a high chip-select.
- R8: The enable outputs for each mode are as follows:
  - Ready and transmitter-off: reg_en and rx_en.
  - Operation: reg_en, rx_en, tx_en and pullup_en.
  - Power-down: wake_en only.
  - Power-on reset: none.
- R9: tx_en is 0 in any cycle in which the synchronized regulator-good flag is low, including cycles in operation mode.
- R10: rst_pull_low (1 means drive low) is 1 in power-on reset or whenever the synchronized regulator-good flag is low. Otherwise it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sup_above_on | input | 1 | Supply is above the turn-on level |
| sup_below_off | input | 1 | Supply is below the turn-off level |
| reg_good | input | 1 | Regulator output is above 80% of nominal |
| cs_wake | input | 1 | Chip-select / local-wake pin |
| txd_pin | input | 1 | Transmit data pin |
| fault | input | 1 | Combined fault flag |
| bus_wake | input | 1 | Wake request from the bus activity detector |
| reg_en | output | 1 | Regulator enable |
| rx_en | output | 1 | Receiver enable |
| tx_en | output | 1 | Transmitter enable |
| pullup_en | output | 1 | Bus pull-up connect |
| wake_en | output | 1 | Wake detector enable |
| rst_pull_low | output | 1 | Reset output: 1 drives low, 0 releases |

## Verification
Two events can fall on the same edge. One is the end of the sleep deglitch count in transmitter-off. The other is a low-supply flag arriving at that moment. The bench sets the supply flag so that its synchronized value rises in exactly the cycle the count completes. It expects the block to land in power-on reset, not power-down, and judges this by the enable vector. A second same-cycle case is also checked. A regulator-good drop disables the transmitter one cycle before the mode leaves operation, so for one sampled cycle the pull-up is still on while tx_en is already off.

// File: rtl/pm_pkg.sv
// Shared types for the transceiver power-mode controller.
// Assumes: five modes; the enables are a pure function of the mode.
package pm_pkg;

    typedef enum logic [2:0] {
        M_POR   = 3'd0,
        M_READY = 3'd1,
        M_OPER  = 3'd2,
        M_TXOFF = 3'd3,
        M_PDOWN = 3'd4
    } mode_t;

    typedef struct packed {
        logic reg_on;
        logic rx_on;
        logic tx_on;
        logic pu_on;
        logic wk_on;
    } en_t;

    // Translate a mode into its enable set (the tx gate by regulator is applied elsewhere).
    function automatic en_t mode_enables(mode_t m);
        en_t e;
        e = '0;
        case (m)
            M_READY, M_TXOFF: begin e.reg_on = 1'b1; e.rx_on = 1'b1; end
            M_OPER:  begin e.reg_on = 1'b1; e.rx_on = 1'b1; e.tx_on = 1'b1; e.pu_on = 1'b1; end
            M_PDOWN: e.wk_on = 1'b1;
            default: e = '0;
        endcase
        return e;
    endfunction

endpackage

// File: rtl/pm_sync.sv
// Two-stage synchronizer for a bundle of asynchronous flags.
// Assumes: each bit is independent; no multi-bit coherence is needed.
module pm_sync #(
    parameter int W = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] d_sync
);
    logic [W-1:0] stage1;

    // Two flops per bit, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1 <= '0;
            d_sync <= '0;
        end else begin
            stage1 <= d_async;
            d_sync <= stage1;
        end
    end
endmodule

// File: rtl/pm_deglitch.sv
// Counts consecutive cycles of an arm level. Raises done in the cycle
// the count reaches TICKS. Any cycle without arm clears the count.
// Assumes: TICKS >= 1.
module pm_deglitch #(
    parameter int TICKS = 2000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    output logic done
);
    localparam int CW = $clog2(TICKS + 1);
    localparam logic [CW-1:0] LAST = CW'(TICKS - 1);

    logic [CW-1:0] cnt;

    assign done = arm && (cnt == LAST);

    // Run while armed, hold at the last value, clear otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)      cnt <= '0;
        else if (!arm)   cnt <= '0;
        else if (!done)  cnt <= cnt + 1'b1;
    end

    assert_cnt_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LAST);

    assert_cnt_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !arm |=> (cnt == '0));
endmodule

// File: rtl/pm_mode_fsm.sv
// Mode register of the power-mode controller. It takes synchronized flags
// and returns the current mode.
// Assumes: inputs are already synchronous; deg_done comes from the sleep deglitch.
module pm_mode_fsm
    import pm_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  sup_on_s,
    input  logic  sup_off_s,
    input  logic  reg_ok_s,
    input  logic  cs_s,
    input  logic  txd_s,
    input  logic  fault_s,
    input  logic  wake_s,
    input  logic  deg_done,
    output mode_t mode
);
    mode_t mode_nx;
    logic  cs_prev;
    logic  cs_fall;
    logic  go_oper;

    assign cs_fall = cs_prev && !cs_s;
    assign go_oper = cs_s && txd_s && reg_ok_s && !fault_s;

    // Previous synchronized chip-select, for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) cs_prev <= 1'b0;
        else        cs_prev <= cs_s;
    end

    // Next-mode decision; brownout wins over everything.
    always_comb begin
        mode_nx = mode;
        if (sup_off_s) begin
            mode_nx = M_POR;
        end else begin
            case (mode)
                M_POR:   if (sup_on_s) mode_nx = M_READY;
                M_READY: begin
                    if (go_oper)                          mode_nx = M_OPER;
                    else if (cs_s && !txd_s && reg_ok_s)  mode_nx = M_TXOFF;
                end
                M_OPER:  if (cs_fall || fault_s || !reg_ok_s) mode_nx = M_TXOFF;
                M_TXOFF: begin
                    if (go_oper)       mode_nx = M_OPER;
                    else if (deg_done) mode_nx = M_PDOWN;
                end
                M_PDOWN: if (wake_s || cs_s) mode_nx = M_READY;
                default: mode_nx = M_POR;
            endcase
        end
    end

    // Mode register.
    always_ff @(posedge clk) begin
        if (!rst_n) mode <= M_POR;
        else        mode <= mode_nx;
    end

    assert_brownout_por_R2: assert property (@(posedge clk) disable iff (!rst_n)
        sup_off_s |=> (mode == M_POR));

    assert_oper_entry_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != M_OPER) ##1 (mode == M_OPER) |-> $past(cs_s && txd_s && reg_ok_s && !fault_s));

    assert_cs_fall_exit_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == M_OPER && cs_fall && !sup_off_s) |=> (mode == M_TXOFF));

    assert_sleep_source_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != M_PDOWN) ##1 (mode == M_PDOWN) |-> ($past(mode) == M_TXOFF && $past(deg_done)));
endmodule

// File: rtl/xcvr_pm_ctrl.sv
// Top of the transceiver power-mode controller. It synchronizes the flags,
// runs the sleep deglitch, holds the mode and decodes the enables.
// Assumes: rst_n is synchronous and active low; all other inputs are asynchronous.
module xcvr_pm_ctrl
    import pm_pkg::*;
#(
    parameter int DEGLITCH_TICKS = 2000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sup_above_on,
    input  logic sup_below_off,
    input  logic reg_good,
    input  logic cs_wake,
    input  logic txd_pin,
    input  logic fault,
    input  logic bus_wake,
    output logic reg_en,
    output logic rx_en,
    output logic tx_en,
    output logic pullup_en,
    output logic wake_en,
    output logic rst_pull_low
);
    localparam int NUM_IN = 7;

    logic [NUM_IN-1:0] raw_in;
    logic [NUM_IN-1:0] syn_in;
    logic  sup_on_s, sup_off_s, reg_ok_s, cs_s, txd_s, fault_s, wake_s;
    logic  deg_arm, deg_done;
    mode_t mode;
    en_t   en;

    assign raw_in = {sup_above_on, sup_below_off, reg_good, cs_wake, txd_pin, fault, bus_wake};
    assign {sup_on_s, sup_off_s, reg_ok_s, cs_s, txd_s, fault_s, wake_s} = syn_in;

    pm_sync #(.W(NUM_IN)) sync_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (raw_in),
        .d_sync  (syn_in)
    );

    assign deg_arm = (mode == M_TXOFF) && !cs_s && !txd_s;

    pm_deglitch #(.TICKS(DEGLITCH_TICKS)) deglitch_i (
        .clk   (clk),
        .rst_n (rst_n),
        .arm   (deg_arm),
        .done  (deg_done)
    );

    pm_mode_fsm fsm_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .sup_on_s  (sup_on_s),
        .sup_off_s (sup_off_s),
        .reg_ok_s  (reg_ok_s),
        .cs_s      (cs_s),
        .txd_s     (txd_s),
        .fault_s   (fault_s),
        .wake_s    (wake_s),
        .deg_done  (deg_done),
        .mode      (mode)
    );

    // Output decode; the transmitter is also gated by regulator health.
    always_comb begin
        en           = mode_enables(mode);
        reg_en       = en.reg_on;
        rx_en        = en.rx_on;
        tx_en        = en.tx_on && reg_ok_s;
        pullup_en    = en.pu_on;
        wake_en      = en.wk_on;
        rst_pull_low = (mode == M_POR) || !reg_ok_s;
    end

    assert_tx_needs_reg_R9: assert property (@(posedge clk) disable iff (!rst_n)
        tx_en |-> (reg_en && reg_ok_s && pullup_en));

    assert_pullup_oper_R8: assert property (@(posedge clk) disable iff (!rst_n)
        pullup_en |-> (mode == M_OPER && !wake_en));
endmodule

// File: tb/xcvr_pm_ctrl_tb_top.sv
// Directed bench for the transceiver power-mode controller.
module xcvr_pm_ctrl_tb_top;
    localparam int T = 16;

    // Expected output vectors {reg, rx, tx, pullup, wake, rst_low}
    localparam logic [5:0] V_POR   = 6'b000001;
    localparam logic [5:0] V_RDY   = 6'b110000;
    localparam logic [5:0] V_OPER  = 6'b111100;
    localparam logic [5:0] V_PDOWN = 6'b000010;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sup_above_on = 0, sup_below_off = 0, reg_good = 0;
    logic cs_wake = 0, txd_pin = 0, fault = 0, bus_wake = 0;
    logic reg_en, rx_en, tx_en, pullup_en, wake_en, rst_pull_low;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    xcvr_pm_ctrl #(.DEGLITCH_TICKS(T)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .sup_above_on(sup_above_on), .sup_below_off(sup_below_off),
        .reg_good(reg_good), .cs_wake(cs_wake), .txd_pin(txd_pin),
        .fault(fault), .bus_wake(bus_wake),
        .reg_en(reg_en), .rx_en(rx_en), .tx_en(tx_en),
        .pullup_en(pullup_en), .wake_en(wake_en), .rst_pull_low(rst_pull_low)
    );

    function automatic logic [5:0] outs();
        return {reg_en, rx_en, tx_en, pullup_en, wake_en, rst_pull_low};
    endfunction

    task automatic chk(input string req, input logic [5:0] exp);
        n_chk++;
        if (outs() !== exp) begin
            n_bad++;
            $display("FAIL %s: outputs %b expected %b", req, outs(), exp);
        end
    endtask

    task automatic settle();
        repeat (4) @(posedge clk);
        #1;
    endtask

    task automatic drive_at_negedge();
        @(negedge clk);
    endtask

    task automatic t_reset();
        rst_n = 0;
        repeat (3) @(posedge clk);
        #1;
        chk("R1 reset state", V_POR);
        @(negedge clk); rst_n = 1;
        settle();
        chk("R1 stays in reset mode without supply", V_POR);
    endtask

    task automatic t_power_up();
        drive_at_negedge(); sup_above_on = 1; reg_good = 1;
        settle();
        chk("R2 power-on reset to ready", V_RDY);
    endtask

    task automatic t_ready_oper();
        drive_at_negedge(); txd_pin = 1; cs_wake = 1;
        settle();
        chk("R3 R8 ready to operation", V_OPER);
    endtask

    task automatic t_cs_fall();
        drive_at_negedge(); cs_wake = 0;
        settle();
        chk("R5 chip-select fall leaves operation", V_RDY);
        drive_at_negedge(); cs_wake = 1;
        settle();
        chk("R3 transmitter-off to operation", V_OPER);
    endtask

    task automatic t_fault();
        drive_at_negedge(); fault = 1;
        settle();
        chk("R5 fault leaves operation", V_RDY);
        repeat (4) @(posedge clk); #1;
        chk("R3 fault blocks return to operation", V_RDY);
        drive_at_negedge(); fault = 0;
        settle();
        chk("R3 return after fault clears", V_OPER);
    endtask

    task automatic t_reg_bad();
        drive_at_negedge(); reg_good = 0;
        repeat (2) @(posedge clk); #1;
        chk("R9 R10 tx gated while mode still operation", 6'b110101);
        @(posedge clk); #1;
        chk("R5 regulator loss leaves operation", 6'b110001);
        drive_at_negedge(); reg_good = 1;
        settle();
        chk("R3 regulator back returns to operation", V_OPER);
    endtask

    // Pins go low before edge 1; power-down visible after edge T+2.
    task automatic sleep_window(input string req);
        repeat (T + 1) @(posedge clk); #1;
        chk({req, " not yet asleep"}, V_RDY);
        @(posedge clk); #1;
        chk({req, " asleep on time"}, V_PDOWN);
    endtask

    task automatic t_deglitch();
        drive_at_negedge(); cs_wake = 0;
        settle();
        drive_at_negedge(); txd_pin = 0;
        sleep_window("R6");
    endtask

    task automatic t_wake_cs();
        drive_at_negedge(); cs_wake = 1;
        settle();
        chk("R7 chip-select wakes", V_RDY);
        drive_at_negedge(); cs_wake = 0;
        sleep_window("R4 ready to transmitter-off then R6");
    endtask

    task automatic t_wake_bus();
        drive_at_negedge(); bus_wake = 1;
        repeat (3) @(negedge clk);
        bus_wake = 0;
        settle();
        chk("R7 bus wake to ready", V_RDY);
        repeat (T + 4) @(posedge clk); #1;
        chk("R6 ready with low pins does not sleep", V_RDY);
    endtask

    task automatic t_restart();
        drive_at_negedge(); cs_wake = 1;
        settle();
        drive_at_negedge(); cs_wake = 0;
        repeat (T / 2) @(negedge clk);
        txd_pin = 1;
        repeat (3) @(negedge clk);
        txd_pin = 0;
        sleep_window("R6 restart");
    endtask

    task automatic t_collide();
        drive_at_negedge(); cs_wake = 1;
        settle();
        drive_at_negedge(); cs_wake = 0;
        repeat (T - 1) @(negedge clk);
        sup_below_off = 1;
        repeat (3) @(posedge clk); #1;
        chk("R2 brownout beats sleep", V_POR);
        drive_at_negedge(); sup_below_off = 0;
        settle();
        chk("R2 recover to ready", V_RDY);
    endtask

    initial begin
        t_reset();
        t_power_up();
        t_ready_oper();
        t_cs_fall();
        t_fault();
        t_reg_bad();
        t_deglitch();
        t_wake_cs();
        t_wake_bus();
        t_restart();
        t_collide();
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++; n_bad++;
            $display("FAIL watchdog: run did not complete, actual hung expected done");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end
endmodule